// File: doc/BRIEF.md
# Segmented Capture Memory Address Sequencer

This block sits between a free-running ADC and an external sample memory. The memory is split into a power-of-two number of equal regions. The block drives the write address and the write strobe for each stored sample. While it waits for a trigger it keeps filling the active region as a ring, so the samples taken before the trigger are kept. When a trigger is accepted, it notes the address where the trigger fell. It then stores a programmed number of further samples.

When that post-trigger fill is complete, the block saves a descriptor for the run. The descriptor holds the region number, the trigger offset, the decimation gap seen at the trigger, and the fine timing value that the interpolation hardware presents at that moment. The descriptor goes into a small queue. The block then moves on to the next region in round-robin order for the next run.

The readout side takes descriptors from the queue in order. It uses the timing data in each descriptor to interleave the runs for display. If every region holds a run that has not yet been read out, capture stops until the readout frees one region.

Top module: `acq_mem_ctrl`

## Requirements
- R1: After reset, `wrEn` is 0 with no strobe, `descValid` is 0, `acqFull` is 0 and `wrAddr` is 0.
- R2: `wrAddr` is `region * 2^ADDR_W + offset`. Each stored sample raises the offset by one. The offset wraps from its top value to 0 and stays inside the same region.
- R3: When a trigger is accepted, `descTrigPtr` records the offset held in that cycle. A sample stored in the trigger cycle is written at that offset and is the first post-trigger sample.
- R4: After an accepted trigger, exactly `postDepth` samples are stored (the setting must be 1 or more). In the next cycle there is no write, even if a strobe is present. In that same cycle the run's descriptor is queued.
- R5: `descInterp` is the `interpIn` value present in the cycle that completes the run, not the value present at the trigger.
- R6: The next run starts at offset 0 of the next region, taken in round-robin order.
- R7: A trigger is ignored when fewer than `preDepth` samples have been stored in the current region since the region was entered.
- R8: With decimation setting N, a strobe is stored only when N unstored strobes have passed since the last stored one. After reset, that count starts at 0. `descGap` holds the number of unstored strobes since the last stored sample, as counted in the trigger cycle.
- R9: `acqFull` is 1 while the queue holds one descriptor for every region. While it is 1, no sample is written and triggers are ignored. A pop clears it.
- R10: Descriptors leave the queue in the order the runs completed. The head is held until `descPop` is asserted. A push and a pop in the same cycle leave the number of queued descriptors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | An ADC sample is available this cycle |
| trigIn | input | 1 | Trigger event |
| preDepth | input | ADDR_W | Samples needed in the region before a trigger is accepted |
| postDepth | input | ADDR_W | Samples to store after the trigger |
| decimN | input | DEC_W | Number of strobes skipped between stored samples |
| interpIn | input | INTERP_W | Fine timing value from the interpolator |
| wrEn | output | 1 | Memory write strobe |
| wrAddr | output | ADDR_W+log2(REGIONS) | Memory write address |
| descValid | output | 1 | The queue head holds a descriptor |
| descPop | input | 1 | Remove the queue head |
| descRegion | output | log2(REGIONS) | Region of the head run |
| descTrigPtr | output | ADDR_W | Trigger offset of the head run |
| descGap | output | DEC_W | Decimation gap at the trigger |
| descInterp | output | INTERP_W | Interpolation value of the head run |
| acqFull | output | 1 | Every region holds an unread run |

## Verification
The risky coincidence is a run completing in the same cycle that the readout pops the queue. In that case the descriptor count must stay the same. If the count were wrongly raised to the full value, capture would halt. To provoke this, three runs are queued and the fourth run is completed with `descPop` held high in its completion cycle. The test then checks that `acqFull` stays low, that the head moves on to the second run, and that the next strobe writes at offset 0 of the region that was just freed.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic {ST_PRE, ST_POST} acqState_t;

  typedef struct packed {
    logic store;
    logic trigTake;
    logic finish;
  } acqStrobes_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEC_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              trigIn,
  input  logic [ADDR_W-1:0] preDepth,
  input  logic [ADDR_W-1:0] postDepth,
  input  logic [DEC_W-1:0]  decimN,
  input  logic              fifoFull,
  output acqStrobes_t       strb,
  output logic [DEC_W-1:0]  gapNow
);
  acqState_t         state;
  logic [ADDR_W:0]   fillCnt;
  logic [ADDR_W:0]   postCnt;
  logic [DEC_W-1:0]  gapCnt;
  logic              eligible;

  always_comb begin
    eligible      = sampleStb && (gapCnt >= decimN);
    strb.finish   = (state == ST_POST) && (postCnt >= {1'b0, postDepth});
    strb.store    = eligible && !fifoFull && !strb.finish;
    strb.trigTake = (state == ST_PRE) && trigIn && !fifoFull &&
                    (fillCnt >= {1'b0, preDepth});
    gapNow        = gapCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PRE;
      fillCnt <= '0;
      postCnt <= '0;
      gapCnt  <= '0;
    end else begin
      if (eligible)       gapCnt <= '0;
      else if (sampleStb) gapCnt <= gapCnt + 1'b1;

      case (state)
        ST_PRE: begin
          if (strb.trigTake) begin
            state   <= ST_POST;
            postCnt <= {{ADDR_W{1'b0}}, strb.store};
          end else if (strb.store && !fillCnt[ADDR_W]) begin
            fillCnt <= fillCnt + 1'b1;
          end
        end
        default: begin
          if (strb.finish) begin
            state   <= ST_PRE;
            fillCnt <= '0;
          end else if (strb.store) begin
            postCnt <= postCnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
  import acq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REGIONS  = 4,
  parameter int DEC_W    = 4,
  parameter int INTERP_W = 8,
  localparam int REG_W   = $clog2(REGIONS),
  localparam int DESC_W  = REG_W + ADDR_W + DEC_W + INTERP_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  acqStrobes_t             strb,
  input  logic [DEC_W-1:0]        gapNow,
  input  logic [INTERP_W-1:0]     interpIn,
  input  logic                    descPop,
  output logic                    wrEn,
  output logic [REG_W+ADDR_W-1:0] wrAddr,
  output logic                    descValid,
  output logic [REG_W-1:0]        descRegion,
  output logic [ADDR_W-1:0]       descTrigPtr,
  output logic [DEC_W-1:0]        descGap,
  output logic [INTERP_W-1:0]     descInterp,
  output logic                    fifoFull
);
  logic [REG_W-1:0]  region;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] trigPtrQ;
  logic [DEC_W-1:0]  trigGapQ;

  logic [DESC_W-1:0] mem [REGIONS];
  logic [REG_W-1:0]  wrIdx, rdIdx;
  logic [REG_W:0]    count;
  logic              push, pop;

  assign wrEn     = strb.store;
  assign wrAddr   = {region, ptr};
  assign push     = strb.finish;
  assign pop      = descPop && (count != '0);
  assign fifoFull = (count == REGIONS[REG_W:0]);
  assign descValid = (count != '0);
  assign {descRegion, descTrigPtr, descGap, descInterp} = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      region   <= '0;
      ptr      <= '0;
      trigPtrQ <= '0;
      trigGapQ <= '0;
    end else begin
      if (strb.trigTake) begin
        trigPtrQ <= ptr;
        trigGapQ <= gapNow;
      end
      if (strb.finish) begin
        region <= region + 1'b1;
        ptr    <= '0;
      end else if (strb.store) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (push) wrIdx <= wrIdx + 1'b1;
      if (pop)  rdIdx <= rdIdx + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrIdx] <= {region, trigPtrQ, trigGapQ, interpIn};
  end
endmodule

// File: rtl/acq_mem_ctrl.sv
module acq_mem_ctrl
  import acq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REGIONS  = 4,
  parameter int DEC_W    = 4,
  parameter int INTERP_W = 8,
  localparam int REG_W   = $clog2(REGIONS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStb,
  input  logic                    trigIn,
  input  logic [ADDR_W-1:0]       preDepth,
  input  logic [ADDR_W-1:0]       postDepth,
  input  logic [DEC_W-1:0]        decimN,
  input  logic [INTERP_W-1:0]     interpIn,
  output logic                    wrEn,
  output logic [REG_W+ADDR_W-1:0] wrAddr,
  output logic                    descValid,
  input  logic                    descPop,
  output logic [REG_W-1:0]        descRegion,
  output logic [ADDR_W-1:0]       descTrigPtr,
  output logic [DEC_W-1:0]        descGap,
  output logic [INTERP_W-1:0]     descInterp,
  output logic                    acqFull
);
  acqStrobes_t      strb;
  logic [DEC_W-1:0] gapNow;
  logic             fifoFull;

  acq_ctrl #(.ADDR_W(ADDR_W), .DEC_W(DEC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .trigIn(trigIn),
    .preDepth(preDepth), .postDepth(postDepth), .decimN(decimN),
    .fifoFull(fifoFull), .strb(strb), .gapNow(gapNow)
  );

  acq_datapath #(.ADDR_W(ADDR_W), .REGIONS(REGIONS), .DEC_W(DEC_W),
                 .INTERP_W(INTERP_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .gapNow(gapNow),
    .interpIn(interpIn), .descPop(descPop), .wrEn(wrEn), .wrAddr(wrAddr),
    .descValid(descValid), .descRegion(descRegion),
    .descTrigPtr(descTrigPtr), .descGap(descGap), .descInterp(descInterp),
    .fifoFull(fifoFull)
  );

  assign acqFull = fifoFull;
endmodule

// File: rtl/acq_mem_ctrl_chk.sv
module acq_mem_ctrl_chk #(
  parameter int ADDR_W   = 4,
  parameter int REGIONS  = 4,
  parameter int INTERP_W = 8,
  localparam int REG_W   = $clog2(REGIONS)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [REG_W+ADDR_W-1:0] wrAddr,
  input logic                    finish,
  input logic                    acqFull,
  input logic                    descValid,
  input logic                    descPop,
  input logic [ADDR_W-1:0]       descTrigPtr,
  input logic [INTERP_W-1:0]     descInterp
);
  a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    acqFull |-> !wrEn);

  a_r4_idle_on_finish: assert property (@(posedge clk) disable iff (!rstN)
    finish |-> !wrEn);

  a_r2_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !finish) |=> wrAddr[ADDR_W-1:0] == $past(wrAddr[ADDR_W-1:0]) + 1'b1);

  a_r6_next_region: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (wrAddr[ADDR_W +: REG_W] == $past(wrAddr[ADDR_W +: REG_W]) + 1'b1)
               && (wrAddr[ADDR_W-1:0] == '0));

  a_r10_head_held: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descPop) |=> descValid && $stable(descTrigPtr) && $stable(descInterp));
endmodule

bind acq_mem_ctrl acq_mem_ctrl_chk #(.ADDR_W(ADDR_W), .REGIONS(REGIONS),
                                     .INTERP_W(INTERP_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .finish(strb.finish),
  .acqFull(acqFull), .descValid(descValid), .descPop(descPop),
  .descTrigPtr(descTrigPtr), .descInterp(descInterp)
);

// File: tb/acq_mem_ctrl_test.sv
module acq_mem_ctrl_test;
  localparam int AW = 4;
  localparam int NR = 4;
  localparam int DW = 4;
  localparam int IW = 8;
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rstN, sampleStb, trigIn, descPop;
  logic [AW-1:0] preDepth, postDepth;
  logic [DW-1:0] decimN;
  logic [IW-1:0] interpIn;
  logic wrEn, descValid, acqFull;
  logic [RW+AW-1:0] wrAddr;
  logic [RW-1:0] descRegion;
  logic [AW-1:0] descTrigPtr;
  logic [DW-1:0] descGap;
  logic [IW-1:0] descInterp;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acq_mem_ctrl #(.ADDR_W(AW), .REGIONS(NR), .DEC_W(DW), .INTERP_W(IW)) uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .trigIn(trigIn),
    .preDepth(preDepth), .postDepth(postDepth), .decimN(decimN),
    .interpIn(interpIn), .wrEn(wrEn), .wrAddr(wrAddr), .descValid(descValid),
    .descPop(descPop), .descRegion(descRegion), .descTrigPtr(descTrigPtr),
    .descGap(descGap), .descInterp(descInterp), .acqFull(acqFull)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, settle, leave outputs ready to check.
  task automatic cyc(input logic s, input logic t);
    @(negedge clk);
    sampleStb = s;
    trigIn = t;
    descPop = 1'b0;
    #1;
  endtask

  task automatic doReset(input int pre, input int post, input int dec);
    @(negedge clk);
    rstN = 1'b0; sampleStb = 0; trigIn = 0; descPop = 0; interpIn = '0;
    preDepth = AW'(pre); postDepth = AW'(post); decimN = DW'(dec);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset(4, 3, 0);
    #1;
    chk("R1 wrEn", int'(wrEn), 0);
    chk("R1 descValid", int'(descValid), 0);
    chk("R1 acqFull", int'(acqFull), 0);
    chk("R1 wrAddr", int'(wrAddr), 0);
  endtask

  task automatic testBasicRun();
    doReset(4, 3, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0);
      chk("R2 pre address", int'(wrAddr), i);
      chk("R2 pre write", int'(wrEn), 1);
    end
    interpIn = 8'h11;
    cyc(1, 1);
    chk("R3 trigger sample address", int'(wrAddr), 6);
    chk("R3 trigger sample write", int'(wrEn), 1);
    cyc(1, 0); chk("R4 post 2", int'(wrAddr), 7);
    cyc(1, 0); chk("R4 post 3", int'(wrAddr), 8);
    interpIn = 8'h5A;
    cyc(1, 0);
    chk("R4 no write at completion", int'(wrEn), 0);
    chk("R4 not yet queued", int'(descValid), 0);
    cyc(1, 0);
    chk("R4 descriptor queued", int'(descValid), 1);
    chk("R3 trigger offset", int'(descTrigPtr), 6);
    chk("R5 interp at completion", int'(descInterp), 8'h5A);
    chk("R6 descriptor region", int'(descRegion), 0);
    chk("R6 next region start", int'(wrAddr), 16);
    chk("R6 next region write", int'(wrEn), 1);
  endtask

  task automatic testEarlyTrigger();
    doReset(4, 3, 0);
    cyc(1, 0); cyc(1, 0);
    cyc(1, 1);
    chk("R7 early trigger sample", int'(wrAddr), 2);
    for (int i = 3; i < 8; i++) begin
      cyc(1, 0);
      chk("R7 early trigger ignored addr", int'(wrAddr), i);
      chk("R7 early trigger ignored write", int'(wrEn), 1);
    end
    chk("R7 no descriptor", int'(descValid), 0);
  endtask

  task automatic testWrap();
    doReset(15, 3, 0);
    for (int i = 0; i < 16; i++) cyc(1, 0);
    chk("R2 last offset", int'(wrAddr), 15);
    cyc(1, 0);
    chk("R2 wrap to offset 0 same region", int'(wrAddr), 0);
    chk("R2 wrap write", int'(wrEn), 1);
  endtask

  task automatic testDecimation();
    doReset(1, 1, 2);
    cyc(1, 0); chk("R8 skip 1", int'(wrEn), 0);
    cyc(1, 0); chk("R8 skip 2", int'(wrEn), 0);
    cyc(1, 0); chk("R8 store", int'(wrEn), 1); chk("R8 store addr", int'(wrAddr), 0);
    cyc(1, 0); chk("R8 skip after store", int'(wrEn), 0);
    cyc(1, 1); chk("R8 trigger on skipped strobe", int'(wrEn), 0);
    cyc(1, 0); chk("R8 post store", int'(wrEn), 1); chk("R8 post addr", int'(wrAddr), 1);
    cyc(0, 0);
    cyc(0, 0);
    chk("R8 descriptor", int'(descValid), 1);
    chk("R8 gap at trigger", int'(descGap), 1);
    chk("R3 decimated trigger offset", int'(descTrigPtr), 1);
  endtask

  task automatic oneRun(input int r, input bit popAtEnd);
    cyc(1, 0); chk("R6 run start addr", int'(wrAddr), r * 16);
    cyc(1, 1); chk("R3 run trigger addr", int'(wrAddr), r * 16 + 1);
    @(negedge clk);
    sampleStb = 0; trigIn = 0; descPop = popAtEnd;
    #1;
  endtask

  task automatic testFull();
    doReset(1, 1, 0);
    for (int r = 0; r < NR; r++) oneRun(r, 0);
    cyc(1, 1);
    chk("R9 full flag", int'(acqFull), 1);
    chk("R9 no write when full", int'(wrEn), 0);
    chk("R10 head is first run", int'(descRegion), 0);
    @(negedge clk);
    sampleStb = 0; trigIn = 0; descPop = 1;
    cyc(1, 0);
    chk("R9 full cleared", int'(acqFull), 0);
    chk("R10 head after pop", int'(descRegion), 1);
    chk("R9 write resumes in freed region", int'(wrAddr), 0);
    chk("R9 write resumes", int'(wrEn), 1);
  endtask

  task automatic testPushPop();
    doReset(1, 1, 0);
    for (int r = 0; r < NR - 1; r++) oneRun(r, 0);
    oneRun(NR - 1, 1);
    cyc(1, 0);
    chk("R10 push and pop keeps count", int'(acqFull), 0);
    chk("R10 head advanced", int'(descRegion), 1);
    chk("R10 write into freed region", int'(wrEn), 1);
    chk("R10 freed region address", int'(wrAddr), 0);
  endtask

  initial begin
    rstN = 0; sampleStb = 0; trigIn = 0; descPop = 0;
    preDepth = '0; postDepth = '0; decimN = '0; interpIn = '0;
    testReset();
    testBasicRun();
    testEarlyTrigger();
    testWrap();
    testDecimation();
    testFull();
    testPushPop();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule